// File: doc/BRIEF.md
# Display Controller Shadowed Register Bank

This block is the software-visible settings store of a display controller. A host writes timing words, panel sizes, per-output background and colour-key values, a pipeline configuration word and the graphics-layer placement through a plain 32-bit register port. Every such write lands in a shadow copy. The copies that the display pipeline uses sit on the `act_*` output ports, and they change only when software arms a GO bit for an output and the next vertical-sync pulse arrives. At that edge the shadow contents move across in one step, so the pipeline never sees a half-updated frame setup.

There are two outputs, the LCD panel and the digital output. Each has its own size, background colour and key colour. The shared settings (configuration, line number, four timing words and the graphics layer) move with either GO. The block also keeps an interrupt status/enable pair that drives one level-sensitive interrupt line. A frame-done event sets status bit 0. A palette-load-done pulse steps the palette load-mode field of the configuration word back by itself.

Reads are combinational from `reg_addr` and return shadow copies. Unmapped offsets read as zero. Writes take effect at the clock edge where `reg_wr` is high. The register port has no handshake: every access completes in the cycle in which it is presented.

Top module: `dispctl_shadow_regs`

## Requirements
- R1: `irq` is high exactly when the status register (0x04) ANDed with the enable register (0x08) is non-zero; the enable register stores only bits 15:0 and reads back zero above them.
- R2: Writing the status register (0x04) clears each status bit written as 1 and leaves bits written as 0 unchanged.
- R3: A `frame_done` pulse sets status bit 0; when a set and a clear of that bit fall in the same cycle, the set wins.
- R4: The control register (0x0C) keeps mask 0x07ff9fff; its bit 0 drives `lcd_en` and its bit 1 drives `dig_en`.
- R5: Control bit 5 (LCD GO) and bit 6 (digital GO) read back as 1 from the write that sets them until a `vsync` pulse is seen; at that edge the GO is accepted and reads 0 afterwards.
- R6: An accepted LCD GO copies the shared settings plus the LCD size (0x3C), colour 0 (0x14) and key 0 (0x1C) to the active ports; an accepted digital GO copies the shared settings plus the digital size (0x38), colour 1 (0x18) and key 1 (0x20); the other output's active values stay as they were.
- R7: Register reads return shadow values, and writes change no `act_*` port until a GO is accepted.
- R8: Size registers (0x38, 0x3C, 0x48) hold width-1 in bits 10:0 and height-1 in bits 26:16, read back in that encoding; the layer position (0x44) holds X in bits 10:0 and Y in bits 26:16; all four keep mask 0x07ff07ff.
- R9: Write masks: timing H/V (0x28, 0x2C) 0x0ff0ff3f, polarity/frequency (0x30) 0x0003ffff, divisor (0x34) 0x00ff00ff, colours and keys 0x00ffffff, config (0x10) 0x3fff, line number (0x24) 0x7ff, layer threshold (0x4C) 0x01ff01ff; base (0x40) and row/pixel increments (0x50, 0x54) keep all 32 bits.
- R10: On a `pal_load_done` pulse, config load-mode bits 2:1 go from 1 to 0 and from 3 to 2; values 0 and 2 stay; a config write in the same cycle wins.
- R11: Writing bit 1 of the system register (0x00) resets every shadow, active, control and interrupt register to its reset value at that edge.
- R12: After reset all sizes read 0 (meaning 1x1), both increments read 1, all other registers read 0 and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 8 | Byte offset of the accessed register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| frame_done | input | 1 | Frame-complete event pulse |
| vsync | input | 1 | Vertical-sync pulse that accepts pending GO bits |
| pal_load_done | input | 1 | Palette-load-complete pulse |
| irq | output | 1 | Level interrupt |
| lcd_en | output | 1 | LCD output enable |
| dig_en | output | 1 | Digital output enable |
| act_cfg | output | 14 | Active configuration word |
| act_line | output | 11 | Active line number |
| act_tim_h | output | 32 | Active horizontal timing |
| act_tim_v | output | 32 | Active vertical timing |
| act_pol_freq | output | 32 | Active polarity/frequency word |
| act_divisor | output | 32 | Active clock divisor word |
| act_gfx_base | output | 32 | Active graphics layer base address |
| act_gfx_pos | output | 32 | Active graphics layer position |
| act_gfx_size | output | 32 | Active graphics layer size (minus-one) |
| act_gfx_thresh | output | 32 | Active graphics fetch thresholds |
| act_row_inc | output | 32 | Active row increment |
| act_pix_inc | output | 32 | Active pixel increment |
| act_lcd_size | output | 32 | Active LCD panel size (minus-one) |
| act_dig_size | output | 32 | Active digital panel size (minus-one) |
| act_lcd_bg | output | 24 | Active LCD background colour |
| act_dig_bg | output | 24 | Active digital background colour |
| act_lcd_key | output | 24 | Active LCD colour key |
| act_dig_key | output | 24 | Active digital colour key |

## Verification
On every cycle the checker watches the GO life cycle: a pending GO holds until `vsync` and drops right after it. It also checks that active ports stay frozen when no GO is accepted and that a digital-only commit leaves the LCD size alone. The remaining cycle checks cover frame-done setting status, the load-mode step-back, the result of a soft reset and `irq` staying low with nothing enabled. The exact masked readback of each register, the minus-one size encoding, the write-one-to-clear rule and the values that land on the active ports after each GO can only be shown by the bench's scenarios, which compare them against values worked out from the requirements.

// File: rtl/dispctl_pkg.sv
package dispctl_pkg;

  localparam int ADDR_W  = 8;
  localparam int DATA_W  = 32;
  localparam int NUM_OUT = 2;
  localparam int OUT_LCD = 0;
  localparam int OUT_DIG = 1;
  localparam int IRQ_W   = 16;
  localparam int CFG_W   = 14;
  localparam int LINE_W  = 11;
  localparam int COL_W   = 24;
  localparam int GO_LSB  = 5;   // LCD GO at GO_LSB, digital GO one above

  // register offsets
  localparam logic [ADDR_W-1:0] A_SYS      = 8'h00;
  localparam logic [ADDR_W-1:0] A_STAT     = 8'h04;
  localparam logic [ADDR_W-1:0] A_IRQEN    = 8'h08;
  localparam logic [ADDR_W-1:0] A_CTRL     = 8'h0C;
  localparam logic [ADDR_W-1:0] A_CFG      = 8'h10;
  localparam logic [ADDR_W-1:0] A_BG0      = 8'h14;
  localparam logic [ADDR_W-1:0] A_BG1      = 8'h18;
  localparam logic [ADDR_W-1:0] A_KEY0     = 8'h1C;
  localparam logic [ADDR_W-1:0] A_KEY1     = 8'h20;
  localparam logic [ADDR_W-1:0] A_LINE     = 8'h24;
  localparam logic [ADDR_W-1:0] A_TIM_H    = 8'h28;
  localparam logic [ADDR_W-1:0] A_TIM_V    = 8'h2C;
  localparam logic [ADDR_W-1:0] A_POLFREQ  = 8'h30;
  localparam logic [ADDR_W-1:0] A_DIV      = 8'h34;
  localparam logic [ADDR_W-1:0] A_SIZE_DIG = 8'h38;
  localparam logic [ADDR_W-1:0] A_SIZE_LCD = 8'h3C;
  localparam logic [ADDR_W-1:0] A_GBASE    = 8'h40;
  localparam logic [ADDR_W-1:0] A_GPOS     = 8'h44;
  localparam logic [ADDR_W-1:0] A_GSIZE    = 8'h48;
  localparam logic [ADDR_W-1:0] A_GTHR     = 8'h4C;
  localparam logic [ADDR_W-1:0] A_ROWINC   = 8'h50;
  localparam logic [ADDR_W-1:0] A_PIXINC   = 8'h54;

  // write masks
  localparam logic [DATA_W-1:0] M_CTRL    = 32'h07ff_9fff;
  localparam logic [DATA_W-1:0] M_TIM     = 32'h0ff0_ff3f;
  localparam logic [DATA_W-1:0] M_POLFREQ = 32'h0003_ffff;
  localparam logic [DATA_W-1:0] M_DIV     = 32'h00ff_00ff;
  localparam logic [DATA_W-1:0] M_XY      = 32'h07ff_07ff;
  localparam logic [DATA_W-1:0] M_THR     = 32'h01ff_01ff;
  localparam logic [DATA_W-1:0] M_GO      = 32'(((1 << NUM_OUT) - 1) << GO_LSB);

  typedef struct packed {
    logic [CFG_W-1:0]  cfg;
    logic [LINE_W-1:0] line;
    logic [DATA_W-1:0] tim_h;
    logic [DATA_W-1:0] tim_v;
    logic [DATA_W-1:0] polfreq;
    logic [DATA_W-1:0] divisor;
    logic [DATA_W-1:0] gbase;
    logic [DATA_W-1:0] gpos;
    logic [DATA_W-1:0] gsize;
    logic [DATA_W-1:0] gthr;
    logic [DATA_W-1:0] rowinc;
    logic [DATA_W-1:0] pixinc;
  } shared_t;

  typedef struct packed {
    logic [DATA_W-1:0] size;
    logic [COL_W-1:0]  bg;
    logic [COL_W-1:0]  key;
  } chan_t;

  localparam shared_t SHARED_RST = '{rowinc: 32'd1, pixinc: 32'd1, default: '0};
  localparam chan_t   CHAN_RST   = '{default: '0};

  function automatic logic [ADDR_W-1:0] size_addr(input int i);
    return (i == OUT_LCD) ? A_SIZE_LCD : A_SIZE_DIG;
  endfunction

  function automatic logic [ADDR_W-1:0] bg_addr(input int i);
    return (i == OUT_LCD) ? A_BG0 : A_BG1;
  endfunction

  function automatic logic [ADDR_W-1:0] key_addr(input int i);
    return (i == OUT_LCD) ? A_KEY0 : A_KEY1;
  endfunction

endpackage

// File: rtl/dispctl_shadow_bank.sv
module dispctl_shadow_bank
  import dispctl_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    soft_rst,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [DATA_W-1:0]       wdata,
  input  logic                    pal_load_done,
  output shared_t                 sh_q,
  output chan_t [NUM_OUT-1:0]     ch_q
);

  // load-mode 1->0 and 3->2 both amount to clearing bit 1 when bit 1 is set
  logic step_load;
  assign step_load = pal_load_done && sh_q.cfg[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= SHARED_RST;
    end else if (soft_rst) begin
      sh_q <= SHARED_RST;
    end else begin
      if (step_load) sh_q.cfg[1] <= 1'b0;
      if (wr_en) begin
        case (addr)
          A_CFG:     sh_q.cfg     <= wdata[CFG_W-1:0];
          A_LINE:    sh_q.line    <= wdata[LINE_W-1:0];
          A_TIM_H:   sh_q.tim_h   <= wdata & M_TIM;
          A_TIM_V:   sh_q.tim_v   <= wdata & M_TIM;
          A_POLFREQ: sh_q.polfreq <= wdata & M_POLFREQ;
          A_DIV:     sh_q.divisor <= wdata & M_DIV;
          A_GBASE:   sh_q.gbase   <= wdata;
          A_GPOS:    sh_q.gpos    <= wdata & M_XY;
          A_GSIZE:   sh_q.gsize   <= wdata & M_XY;
          A_GTHR:    sh_q.gthr    <= wdata & M_THR;
          A_ROWINC:  sh_q.rowinc  <= wdata;
          A_PIXINC:  sh_q.pixinc  <= wdata;
          default: ;
        endcase
      end
    end
  end

  for (genvar g = 0; g < NUM_OUT; g++) begin : g_chan
    localparam logic [ADDR_W-1:0] SZ_A  = size_addr(g);
    localparam logic [ADDR_W-1:0] BG_A  = bg_addr(g);
    localparam logic [ADDR_W-1:0] KEY_A = key_addr(g);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ch_q[g] <= CHAN_RST;
      end else if (soft_rst) begin
        ch_q[g] <= CHAN_RST;
      end else if (wr_en) begin
        if (addr == SZ_A)  ch_q[g].size <= wdata & M_XY;
        if (addr == BG_A)  ch_q[g].bg   <= wdata[COL_W-1:0];
        if (addr == KEY_A) ch_q[g].key  <= wdata[COL_W-1:0];
      end
    end
  end

endmodule

// File: rtl/dispctl_ctrl_go.sv
module dispctl_ctrl_go
  import dispctl_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               soft_rst,
  input  logic               wr_ctrl,
  input  logic [DATA_W-1:0]  wdata,
  input  logic               vsync,
  output logic [DATA_W-1:0]  ctrl_rd,
  output logic [NUM_OUT-1:0] out_en,
  output logic [NUM_OUT-1:0] go_q,
  output logic [NUM_OUT-1:0] take
);

  logic [DATA_W-1:0]  ctrl_q;
  logic [NUM_OUT-1:0] go_set;

  assign go_set = wr_ctrl ? wdata[GO_LSB +: NUM_OUT] : '0;
  assign take   = go_q & {NUM_OUT{vsync}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      go_q   <= '0;
    end else if (soft_rst) begin
      ctrl_q <= '0;
      go_q   <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= wdata & M_CTRL & ~M_GO;
      // an accepted GO drops; a GO written in the same cycle stays pending
      go_q <= (go_q & ~take) | go_set;
    end
  end

  assign ctrl_rd = ctrl_q | (DATA_W'(go_q) << GO_LSB);
  assign out_en  = ctrl_q[NUM_OUT-1:0];

endmodule

// File: rtl/dispctl_active_bank.sv
module dispctl_active_bank
  import dispctl_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                soft_rst,
  input  logic [NUM_OUT-1:0]  take,
  input  shared_t             sh_q,
  input  chan_t [NUM_OUT-1:0] ch_q,
  output shared_t             act_sh,
  output chan_t [NUM_OUT-1:0] act_ch
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          act_sh <= SHARED_RST;
    else if (soft_rst)   act_sh <= SHARED_RST;
    else if (|take)      act_sh <= sh_q;
  end

  for (genvar g = 0; g < NUM_OUT; g++) begin : g_act
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         act_ch[g] <= CHAN_RST;
      else if (soft_rst)  act_ch[g] <= CHAN_RST;
      else if (take[g])   act_ch[g] <= ch_q[g];
    end
  end

endmodule

// File: rtl/dispctl_irq.sv
module dispctl_irq
  import dispctl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             wr_stat,
  input  logic             wr_en_reg,
  input  logic [IRQ_W-1:0] wdata,
  input  logic [IRQ_W-1:0] events,
  output logic [IRQ_W-1:0] stat_q,
  output logic [IRQ_W-1:0] en_q,
  output logic             irq
);

  logic [IRQ_W-1:0] clr;
  assign clr = wr_stat ? wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      en_q   <= '0;
    end else if (soft_rst) begin
      stat_q <= '0;
      en_q   <= '0;
    end else begin
      stat_q <= (stat_q & ~clr) | events;
      if (wr_en_reg) en_q <= wdata;
    end
  end

  assign irq = |(stat_q & en_q);

endmodule

// File: rtl/dispctl_shadow_regs.sv
module dispctl_shadow_regs
  import dispctl_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [7:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        frame_done,
  input  logic        vsync,
  input  logic        pal_load_done,
  output logic        irq,
  output logic        lcd_en,
  output logic        dig_en,
  output logic [13:0] act_cfg,
  output logic [10:0] act_line,
  output logic [31:0] act_tim_h,
  output logic [31:0] act_tim_v,
  output logic [31:0] act_pol_freq,
  output logic [31:0] act_divisor,
  output logic [31:0] act_gfx_base,
  output logic [31:0] act_gfx_pos,
  output logic [31:0] act_gfx_size,
  output logic [31:0] act_gfx_thresh,
  output logic [31:0] act_row_inc,
  output logic [31:0] act_pix_inc,
  output logic [31:0] act_lcd_size,
  output logic [31:0] act_dig_size,
  output logic [23:0] act_lcd_bg,
  output logic [23:0] act_dig_bg,
  output logic [23:0] act_lcd_key,
  output logic [23:0] act_dig_key
);

  shared_t             sh_q, act_sh;
  chan_t [NUM_OUT-1:0] ch_q, act_ch;
  logic [NUM_OUT-1:0]  go_q, take, out_en;
  logic [DATA_W-1:0]   ctrl_rd;
  logic [IRQ_W-1:0]    stat_q, irq_en_q, events;
  logic                soft_rst;

  assign soft_rst = reg_wr && (reg_addr == A_SYS) && reg_wdata[1];
  assign events   = IRQ_W'(frame_done);

  dispctl_shadow_bank u_shadow (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .wr_en(reg_wr),
    .addr(reg_addr), .wdata(reg_wdata), .pal_load_done(pal_load_done),
    .sh_q(sh_q), .ch_q(ch_q)
  );

  dispctl_ctrl_go u_ctrl (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .wr_ctrl(reg_wr && reg_addr == A_CTRL), .wdata(reg_wdata), .vsync(vsync),
    .ctrl_rd(ctrl_rd), .out_en(out_en), .go_q(go_q), .take(take)
  );

  dispctl_active_bank u_active (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .take(take),
    .sh_q(sh_q), .ch_q(ch_q), .act_sh(act_sh), .act_ch(act_ch)
  );

  dispctl_irq u_irq (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .wr_stat(reg_wr && reg_addr == A_STAT),
    .wr_en_reg(reg_wr && reg_addr == A_IRQEN),
    .wdata(reg_wdata[IRQ_W-1:0]), .events(events),
    .stat_q(stat_q), .en_q(irq_en_q), .irq(irq)
  );

  always_comb begin
    case (reg_addr)
      A_STAT:     reg_rdata = DATA_W'(stat_q);
      A_IRQEN:    reg_rdata = DATA_W'(irq_en_q);
      A_CTRL:     reg_rdata = ctrl_rd;
      A_CFG:      reg_rdata = DATA_W'(sh_q.cfg);
      A_BG0:      reg_rdata = DATA_W'(ch_q[OUT_LCD].bg);
      A_BG1:      reg_rdata = DATA_W'(ch_q[OUT_DIG].bg);
      A_KEY0:     reg_rdata = DATA_W'(ch_q[OUT_LCD].key);
      A_KEY1:     reg_rdata = DATA_W'(ch_q[OUT_DIG].key);
      A_LINE:     reg_rdata = DATA_W'(sh_q.line);
      A_TIM_H:    reg_rdata = sh_q.tim_h;
      A_TIM_V:    reg_rdata = sh_q.tim_v;
      A_POLFREQ:  reg_rdata = sh_q.polfreq;
      A_DIV:      reg_rdata = sh_q.divisor;
      A_SIZE_DIG: reg_rdata = ch_q[OUT_DIG].size;
      A_SIZE_LCD: reg_rdata = ch_q[OUT_LCD].size;
      A_GBASE:    reg_rdata = sh_q.gbase;
      A_GPOS:     reg_rdata = sh_q.gpos;
      A_GSIZE:    reg_rdata = sh_q.gsize;
      A_GTHR:     reg_rdata = sh_q.gthr;
      A_ROWINC:   reg_rdata = sh_q.rowinc;
      A_PIXINC:   reg_rdata = sh_q.pixinc;
      default:    reg_rdata = '0;
    endcase
  end

  assign lcd_en         = out_en[OUT_LCD];
  assign dig_en         = out_en[OUT_DIG];
  assign act_cfg        = act_sh.cfg;
  assign act_line       = act_sh.line;
  assign act_tim_h      = act_sh.tim_h;
  assign act_tim_v      = act_sh.tim_v;
  assign act_pol_freq   = act_sh.polfreq;
  assign act_divisor    = act_sh.divisor;
  assign act_gfx_base   = act_sh.gbase;
  assign act_gfx_pos    = act_sh.gpos;
  assign act_gfx_size   = act_sh.gsize;
  assign act_gfx_thresh = act_sh.gthr;
  assign act_row_inc    = act_sh.rowinc;
  assign act_pix_inc    = act_sh.pixinc;
  assign act_lcd_size   = act_ch[OUT_LCD].size;
  assign act_dig_size   = act_ch[OUT_DIG].size;
  assign act_lcd_bg     = act_ch[OUT_LCD].bg;
  assign act_dig_bg     = act_ch[OUT_DIG].bg;
  assign act_lcd_key    = act_ch[OUT_LCD].key;
  assign act_dig_key    = act_ch[OUT_DIG].key;

endmodule

// File: rtl/dispctl_shadow_regs_chk.sv
module dispctl_shadow_regs_chk
  import dispctl_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        reg_wr,
  input logic [7:0]  reg_addr,
  input logic [31:0] reg_wdata,
  input logic        frame_done,
  input logic        vsync,
  input logic        pal_load_done,
  input logic        irq,
  input logic [15:0] irq_en_q,
  input logic [15:0] stat_q,
  input logic [1:0]  go_q,
  input logic [13:0] cfg_q,
  input logic [31:0] act_tim_h,
  input logic [31:0] act_lcd_size,
  input logic [31:0] act_row_inc
);

  logic sr, wr_ctrl_go0, wr_cfg;
  assign sr          = reg_wr && (reg_addr == A_SYS) && reg_wdata[1];
  assign wr_ctrl_go0 = reg_wr && (reg_addr == A_CTRL) && reg_wdata[GO_LSB];
  assign wr_cfg      = reg_wr && (reg_addr == A_CFG);

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en_q == '0) |-> !irq); // R1

  AST_FRAME_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && !sr) |=> stat_q[0]); // R3

  AST_GO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (go_q[0] && !vsync && !sr) |=> go_q[0]); // R5

  AST_GO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (go_q[0] && vsync && !wr_ctrl_go0 && !sr) |=> !go_q[0]); // R5

  AST_ACTIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!(|(go_q & {2{vsync}})) && !sr) |=> $stable(act_tim_h)); // R7

  AST_DIG_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (go_q == 2'b10 && vsync && !sr) |=> $stable(act_lcd_size)); // R6

  AST_LOAD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (pal_load_done && cfg_q[2:1] == 2'b11 && !wr_cfg && !sr) |=> (cfg_q[2:1] == 2'b10)); // R10

  AST_SOFT_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    sr |=> (act_lcd_size == '0 && act_row_inc == 32'd1 && !irq)); // R11

endmodule

bind dispctl_shadow_regs dispctl_shadow_regs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .frame_done(frame_done), .vsync(vsync),
  .pal_load_done(pal_load_done), .irq(irq), .irq_en_q(irq_en_q),
  .stat_q(stat_q), .go_q(go_q), .cfg_q(sh_q.cfg), .act_tim_h(act_tim_h),
  .act_lcd_size(act_lcd_size), .act_row_inc(act_row_inc)
);

// File: tb/dispctl_shadow_regs_test.sv
module dispctl_shadow_regs_test;

  localparam int CLK_NS = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        frame_done = 1'b0, vsync = 1'b0, pal_load_done = 1'b0;
  logic        irq, lcd_en, dig_en;
  logic [13:0] act_cfg;
  logic [10:0] act_line;
  logic [31:0] act_tim_h, act_tim_v, act_pol_freq, act_divisor;
  logic [31:0] act_gfx_base, act_gfx_pos, act_gfx_size, act_gfx_thresh;
  logic [31:0] act_row_inc, act_pix_inc, act_lcd_size, act_dig_size;
  logic [23:0] act_lcd_bg, act_dig_bg, act_lcd_key, act_dig_key;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  dispctl_shadow_regs uut (.*);

  typedef struct packed {
    logic [7:0]  a;
    logic [31:0] w;
    logic [31:0] e;
  } vec_t;

  // write value, expected masked readback (R4, R8, R9, R1)
  localparam vec_t VECS [20] = '{
    '{8'h28, 32'hFFFF_FFFF, 32'h0FF0_FF3F},
    '{8'h2C, 32'h1234_5678, 32'h0230_5638},
    '{8'h30, 32'hFFFF_FFFF, 32'h0003_FFFF},
    '{8'h34, 32'hABCD_EF12, 32'h00CD_0012},
    '{8'h10, 32'hFFFF_FFFF, 32'h0000_3FFF},
    '{8'h14, 32'hFFFF_FFFF, 32'h00FF_FFFF},
    '{8'h18, 32'h1122_3344, 32'h0022_3344},
    '{8'h1C, 32'hAABB_CCDD, 32'h00BB_CCDD},
    '{8'h20, 32'h0102_0304, 32'h0002_0304},
    '{8'h24, 32'hFFFF_FFFF, 32'h0000_07FF},
    '{8'h3C, 32'hFFFF_FFFF, 32'h07FF_07FF},
    '{8'h38, 32'h013F_00EF, 32'h013F_00EF},
    '{8'h44, 32'h1234_5678, 32'h0234_0678},
    '{8'h48, 32'h0063_0031, 32'h0063_0031},
    '{8'h4C, 32'hFFFF_FFFF, 32'h01FF_01FF},
    '{8'h40, 32'h8000_1000, 32'h8000_1000},
    '{8'h50, 32'hFFFF_FFFE, 32'hFFFF_FFFE},
    '{8'h54, 32'h0000_0003, 32'h0000_0003},
    '{8'h0C, 32'hFFFF_FF9F, 32'h07FF_9F9F},
    '{8'h08, 32'hFFFF_FFFF, 32'h0000_FFFF}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic pulse_vsync();
    @(negedge clk); vsync = 1'b1;
    @(negedge clk); vsync = 1'b0;
  endtask

  task automatic pulse_frame();
    @(negedge clk); frame_done = 1'b1;
    @(negedge clk); frame_done = 1'b0;
  endtask

  task automatic pulse_pal();
    @(negedge clk); pal_load_done = 1'b1;
    @(negedge clk); pal_load_done = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_NS * 200000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R12 reset state
    rd(8'h3C, v); chk("R12 lcd size reset", v, 32'h0);
    rd(8'h50, v); chk("R12 row inc reset", v, 32'h1);
    rd(8'h54, v); chk("R12 pixel inc reset", v, 32'h1);
    chk("R12 irq low", {31'h0, irq}, 32'h0);
    chk("R12 active row inc", act_row_inc, 32'h1);

    // table walk: masked readback
    for (int i = 0; i < 20; i++) begin
      wr(VECS[i].a, VECS[i].w);
      rd(VECS[i].a, v);
      chk($sformatf("R9/R8 reg %h", VECS[i].a), v, VECS[i].e);
    end
    chk("R4 lcd_en", {31'h0, lcd_en}, 32'h1);
    chk("R4 dig_en", {31'h0, dig_en}, 32'h1);

    // R7 shadow only, active untouched
    chk("R7 act tim_h frozen", act_tim_h, 32'h0);
    chk("R7 act lcd size frozen", act_lcd_size, 32'h0);

    // R5 / R6 LCD GO
    wr(8'h0C, 32'h0000_0021);
    repeat (4) @(negedge clk);
    rd(8'h0C, v); chk("R5 lcd GO pending", v, 32'h0000_0021);
    chk("R4 lcd only enable", {30'h0, dig_en, lcd_en}, 32'h1);
    chk("R5 no commit before vsync", act_lcd_size, 32'h0);
    pulse_vsync();
    rd(8'h0C, v); chk("R5 lcd GO cleared", v, 32'h0000_0001);
    chk("R6 act tim_h", act_tim_h, 32'h0FF0_FF3F);
    chk("R6 act cfg", {18'h0, act_cfg}, 32'h3FFF);
    chk("R6 act lcd size", act_lcd_size, 32'h07FF_07FF);
    chk("R6 act lcd bg", {8'h0, act_lcd_bg}, 32'h00FF_FFFF);
    chk("R6 act lcd key", {8'h0, act_lcd_key}, 32'h00BB_CCDD);
    chk("R6 act gfx pos", act_gfx_pos, 32'h0234_0678);
    chk("R6 dig size untouched", act_dig_size, 32'h0);
    chk("R6 dig bg untouched", {8'h0, act_dig_bg}, 32'h0);

    // R6 digital GO after changing timing
    wr(8'h28, 32'h0000_0011);
    wr(8'h0C, 32'h0000_0042);
    chk("R7 act tim_h before dig GO", act_tim_h, 32'h0FF0_FF3F);
    pulse_vsync();
    chk("R6 act dig size", act_dig_size, 32'h013F_00EF);
    chk("R6 act dig key", {8'h0, act_dig_key}, 32'h0002_0304);
    chk("R6 shared via dig GO", act_tim_h, 32'h0000_0011);
    chk("R6 lcd size kept", act_lcd_size, 32'h07FF_07FF);
    chk("R4 dig only enable", {30'h0, dig_en, lcd_en}, 32'h2);

    // R1 / R2 / R3 interrupts (enable = 0xFFFF from table)
    chk("R1 irq idle", {31'h0, irq}, 32'h0);
    pulse_frame();
    rd(8'h04, v); chk("R3 frame sets bit0", v, 32'h1);
    chk("R1 irq raised", {31'h0, irq}, 32'h1);
    wr(8'h04, 32'hFFFF_FFFE);
    rd(8'h04, v); chk("R2 zero bit kept", v, 32'h1);
    // R3 set wins over clear in same cycle
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 8'h04; reg_wdata = 32'h1; frame_done = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; frame_done = 1'b0;
    rd(8'h04, v); chk("R3 set beats clear", v, 32'h1);
    wr(8'h04, 32'h1);
    rd(8'h04, v); chk("R2 w1c clears", v, 32'h0);
    chk("R1 irq dropped", {31'h0, irq}, 32'h0);
    wr(8'h08, 32'h0000_0002);
    pulse_frame();
    chk("R1 masked source", {31'h0, irq}, 32'h0);
    wr(8'h04, 32'h1);

    // R10 load-mode step
    wr(8'h10, 32'h0000_0002); pulse_pal();
    rd(8'h10, v); chk("R10 mode1 to 0", v, 32'h0);
    wr(8'h10, 32'h0000_0006); pulse_pal();
    rd(8'h10, v); chk("R10 mode3 to 2", v, 32'h4);
    wr(8'h10, 32'h0000_0004); pulse_pal();
    rd(8'h10, v); chk("R10 mode2 stays", v, 32'h4);

    // R11 soft reset
    wr(8'h08, 32'h0000_FFFF);
    pulse_frame();
    chk("R11 irq before reset", {31'h0, irq}, 32'h1);
    wr(8'h00, 32'h0000_0002);
    rd(8'h3C, v); chk("R11 shadow lcd size", v, 32'h0);
    rd(8'h50, v); chk("R11 row inc", v, 32'h1);
    rd(8'h04, v); chk("R11 status", v, 32'h0);
    chk("R11 act lcd size", act_lcd_size, 32'h0);
    chk("R11 act tim_h", act_tim_h, 32'h0);
    chk("R11 irq", {31'h0, irq}, 32'h0);

    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule